// File: doc/BRIEF.md
# Start-up Current-Limit Mode Sequencer

This block decides which current-limit level the positive output rail of a panel supply uses while it starts up and afterwards. When the rail is switched on, a moderate 150 mA limit is applied for a fixed start-up window. The rail's soft-start ramp is expected to finish well inside this window. On the last cycle of the window the block samples a "target reached" comparator flag. If the rail is at its target, the limit is lifted to the normal, practically unrestricted level. If it is not, the block treats the load as excessive and folds back to a 25 mA limit. It keeps that limit until the comparator reports that the output has recovered.

The window length is a parameter counted in clock cycles. The comparator flag arrives from the analog domain, so it is synchronized before use. The block drives a two-bit limit-select code to the analog current-limit circuit and a one-hot state indication. Dropping the rail enable or applying reset returns the block to its idle state. Current sensing and the regulation loop sit outside the block.

Top module: `startup_limit_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, the block is idle: `limit_sel` = 2'b00 (off) and `state_o` = 4'b0001.
- R2: From idle, `rail_en` sampled high at a clock edge moves the block at that edge into the start-up window, with `limit_sel` = 2'b01 (150 mA) and `state_o` = 4'b0010.
- R3: The start-up window lasts exactly `WINDOW_CYCLES` clock cycles while `rail_en` stays high.
- R4: If the synchronized target flag is high on the cycle the window expires, the block moves to normal operation: `limit_sel` = 2'b10, `state_o` = 4'b0100.
- R5: If the synchronized target flag is low on the cycle the window expires, the block moves to fold-back: `limit_sel` = 2'b11 (25 mA), `state_o` = 4'b1000. The flag's level earlier in the window has no effect.
- R6: Fold-back is held while the target flag stays low. A rise of `target_ok` moves the block to normal `SYNC_STAGES`+1 clock edges later, counting from the first edge that sees the flag high.
- R7: Once in normal operation, the block stays there while `rail_en` is high, whatever `target_ok` does.
- R8: `rail_en` sampled low in any state returns the block to idle at that edge. A later enable starts a full new window.
- R9: `state_o` is always one-hot. Its set bit index equals the `limit_sel` code: 0 = off, 1 = 150 mA, 2 = normal, 3 = 25 mA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on reset) |
| rail_en | input | 1 | Positive rail enable, synchronous to `clk` |
| target_ok | input | 1 | Asynchronous comparator flag: output has reached its target |
| limit_sel | output | 2 | Current-limit select code to the analog limiter |
| state_o | output | 4 | One-hot state: idle, window, normal, fold-back |

## Verification
The assertions assume `rail_en` is already synchronous to `clk`. They also assume `target_ok` is only used after its synchronizer, so the properties are written on the synchronized flag and not on the raw pin. The stimulus changes inputs only on the falling clock edge. Around the end of each window it holds `target_ok` steady for more than `SYNC_STAGES` cycles, so the flag value the block samples at expiry is unambiguous. Random runs choose the final flag level, an early flag pulse, the fold-back recovery delay and mid-window aborts. Directed cases cover reset and back-to-back re-enables.

// File: rtl/slseq_pkg.sv
// Package: shared state and limit-code definitions for the start-up
// current-limit sequencer. The state code doubles as the limit-select code.
package slseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,   // rail off, limiter off
        ST_WINDOW   = 2'b01,   // start-up window, 150 mA limit
        ST_NORMAL   = 2'b10,   // released, normal limit
        ST_FOLDBACK = 2'b11    // excessive load, 25 mA limit
    } slseq_state_t;

    localparam int unsigned NUM_STATES = 4;
endpackage

// File: rtl/slseq_sync.sv
// Module: slseq_sync
// Multi-flop synchronizer for one asynchronous level signal.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse.
module slseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Purpose: shift the level one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= async_in;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/slseq_window_timer.sv
// Module: slseq_window_timer
// Counts the start-up window. Cleared while run is low; raises expire on the
// last cycle of a WINDOW_CYCLES-long run.
// Assumes: run stays high from window entry until expire or abort.
module slseq_window_timer #(
    parameter int unsigned WINDOW_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW   = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

    logic [CW-1:0] count;

    assign expire = run && (count == LAST);

    // Purpose: count cycles spent in the window, restart when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) count <= '0;
        else if (!expire) count <= count + 1'b1;
    end

    // R3: the counter never runs past the last window cycle
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
    // R3: a running window that has not expired keeps counting
    a_r3_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expire) |=> (count == $past(count) + 1'b1) || !rst_n);
endmodule

// File: rtl/slseq_fsm.sv
// Module: slseq_fsm
// Mode state machine: idle -> window -> normal or fold-back, fold-back ->
// normal on recovery, any state -> idle when the rail is disabled.
// Assumes: rail_en is synchronous; tgt_sync is already synchronized.
module slseq_fsm
    import slseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rail_en,
    input  logic         tgt_sync,
    input  logic         win_expire,
    output logic         win_run,
    output slseq_state_t state
);
    slseq_state_t state_nx;

    assign win_run = (state == ST_WINDOW) && rail_en;

    // Purpose: compute the next mode from enable, timer and target flag.
    always_comb begin
        state_nx = state;
        if (!rail_en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_WINDOW;
                ST_WINDOW:   if (win_expire) state_nx = tgt_sync ? ST_NORMAL : ST_FOLDBACK;
                ST_FOLDBACK: if (tgt_sync) state_nx = ST_NORMAL;
                ST_NORMAL:   state_nx = ST_NORMAL;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // Purpose: hold the current mode.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else state <= state_nx;
    end

    // R2: enable from idle opens the window
    a_r2_enter_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rail_en) |=> (state == ST_WINDOW));
    // R4: target reached at expiry releases the limit
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && rail_en && win_expire && tgt_sync) |=> (state == ST_NORMAL));
    // R5: target missed at expiry folds back
    a_r5_foldback: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && rail_en && win_expire && !tgt_sync) |=> (state == ST_FOLDBACK));
    // R3: no exit from the window before expiry while enabled
    a_r3_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && rail_en && !win_expire) |=> (state == ST_WINDOW));
    // R6: fold-back is sticky until recovery
    a_r6_fold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FOLDBACK && rail_en && !tgt_sync) |=> (state == ST_FOLDBACK));
    // R7: normal mode is kept while enabled
    a_r7_normal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && rail_en) |=> (state == ST_NORMAL));
    // R8: disable returns to idle from anywhere
    a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_en |=> (state == ST_IDLE));
endmodule

// File: rtl/startup_limit_sequencer.sv
// Module: startup_limit_sequencer (top)
// Selects the positive-rail current-limit level during and after start-up.
// Assumes: rail_en synchronous to clk; target_ok asynchronous level from a
// comparator; WINDOW_CYCLES >= 2 and SYNC_STAGES >= 2.
module startup_limit_sequencer
    import slseq_pkg::*;
#(
    parameter int unsigned WINDOW_CYCLES = 300,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rail_en,
    input  logic       target_ok,
    output logic [1:0] limit_sel,
    output logic [3:0] state_o
);
    logic         tgt_sync;
    logic         win_run;
    logic         win_expire;
    slseq_state_t state;

    slseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(target_ok), .sync_out(tgt_sync)
    );

    slseq_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(win_run), .expire(win_expire)
    );

    slseq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .tgt_sync(tgt_sync),
        .win_expire(win_expire), .win_run(win_run), .state(state)
    );

    // Purpose: drive the limit code and the one-hot state view from the mode.
    always_comb begin
        limit_sel = state;
        state_o   = 4'b0001 << state;
    end

    // R9: state indication is always one-hot
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_o) == 1);
    // R9: limit code and state bit agree
    a_r9_agree: assert property (@(posedge clk) disable iff (!rst_n)
        state_o[limit_sel] == 1'b1);
endmodule

// File: tb/startup_limit_sequencer_test.sv
module startup_limit_sequencer_test;
    localparam int unsigned WIN  = 40;
    localparam int unsigned SYNC = 2;
    localparam logic [1:0] C_IDLE = 2'b00, C_WIN = 2'b01, C_NORM = 2'b10, C_FOLD = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_en = 1'b0;
    logic target_ok = 1'b0;
    logic [1:0] limit_sel;
    logic [3:0] state_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    startup_limit_sequencer #(.WINDOW_CYCLES(WIN), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .target_ok(target_ok),
        .limit_sel(limit_sel), .state_o(state_o)
    );

    // Expected outcome of a window from the flag level held at expiry.
    function automatic logic [1:0] after_window(input logic tgt);
        return tgt ? C_NORM : C_FOLD;
    endfunction

    function automatic logic [3:0] onehot_of(input logic [1:0] code);
        return 4'b0001 << code;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] exp);
        checks++;
        if (limit_sel !== exp || state_o !== onehot_of(exp)) begin
            fails++;
            $display("FAIL %s: limit_sel=%b state_o=%b expected limit_sel=%b state_o=%b",
                     req, limit_sel, state_o, exp, onehot_of(exp));
        end
    endtask

    // Open a window with the flag at 'tgt' at expiry; optional early pulse.
    task automatic run_window(input logic tgt, input logic early);
        target_ok = early ? ~tgt : tgt;
        rail_en = 1'b1;
        cyc(1);
        chk("R2 window entry", C_WIN);
        cyc(WIN/2);
        target_ok = tgt;
        cyc(WIN - 1 - WIN/2);
        chk("R3 last window cycle", C_WIN);
        cyc(1);
        chk(tgt ? "R4 released at expiry" : "R5 fold-back at expiry", after_window(tgt));
    endtask

    task automatic disable_rail(input string req);
        rail_en = 1'b0;
        cyc(1);
        chk(req, C_IDLE);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        cyc(3);
        chk("R1 idle in reset", C_IDLE);
        rail_en = 1'b1;
        cyc(1);
        chk("R1 reset dominates enable", C_IDLE);
        rail_en = 1'b0;
        rst_n = 1'b1;
        cyc(1);
        chk("R1 idle after reset", C_IDLE);

        // Directed: clean start-up reaches normal, R7 flag toggles ignored
        run_window(1'b1, 1'b0);
        target_ok = 1'b0;
        cyc(5);
        chk("R7 normal held with flag low", C_NORM);
        disable_rail("R8 disable from normal");

        // Directed: flag high early but low at expiry -> fold-back (R5)
        run_window(1'b0, 1'b1);
        cyc(4);
        chk("R6 fold-back sticky", C_FOLD);
        target_ok = 1'b1;
        cyc(SYNC);
        chk("R6 still fold-back inside sync latency", C_FOLD);
        cyc(1);
        chk("R6 recovery to normal", C_NORM);
        disable_rail("R8 disable after recovery");

        // Directed: abort mid-window then a full new window (R8, R3)
        target_ok = 1'b1;
        rail_en = 1'b1;
        cyc(WIN/2);
        disable_rail("R8 abort mid-window");
        run_window(1'b1, 1'b0);
        disable_rail("R8 disable");

        // Random mix
        for (int i = 0; i < 30; i++) begin
            logic tgt;
            logic early;
            int d;
            tgt   = 1'($urandom % 2);
            early = 1'($urandom % 2);
            if ($urandom % 5 == 0) begin
                rail_en = 1'b1;
                cyc(1 + $urandom % (WIN - 1));
                disable_rail("R8 random abort");
            end
            run_window(tgt, early);
            if (!tgt) begin
                d = 1 + $urandom % 12;
                cyc(d);
                chk("R6 random fold-back hold", C_FOLD);
                if ($urandom % 3 == 0) begin
                    disable_rail("R8 disable from fold-back");
                    continue;
                end
                target_ok = 1'b1;
                cyc(SYNC + 1);
                chk("R6 random recovery", C_NORM);
            end
            for (int k = 0; k < 4; k++) begin
                target_ok = 1'($urandom % 2);
                cyc(1 + $urandom % 3);
            end
            chk("R7 random normal hold", C_NORM);
            disable_rail("R8 random disable");
            cyc($urandom % 3);
            chk("R9 idle encoding", C_IDLE);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule